// File: doc/BRIEF.md
# Cascadable Pipelined Parity Checker

This block checks even parity over a word of address and command bits. The parity bit for a word does not arrive with the word. It arrives one or two clock edges later. The block keeps the data parity in step with its late parity bit and combines the two. It puts the combined result on a partial-parity output and also drives an active-low error flag. Both outputs update exactly three clock edges after the data was sampled. The error flag is stretched, so a single odd word holds it low for a fixed number of cycles.

Two copies can be chained. The first copy is strapped low. It takes the controller's parity one cycle after its data, and its error flag goes unused. The second copy is strapped high. Its parity input is the first copy's partial-parity output, which it takes two cycles after its own data. The second copy's error flag then reports parity over both halves of the word.

Two active-low selects gate the outputs. When both selects are high, the outputs and the hold counter freeze. An asynchronous active-low reset forces the partial-parity output low and the flag high. Reset release is synchronised to the clock.

Top module: `casc_parity_chk`

## Requirements
- R1: The partial-parity output equals the XOR of every checked data bit of a word and the parity bit aligned to that word, so an even count of ones gives 0.
- R2: A word sampled on clock edge k produces its partial-parity and error results on edge k+3, in both strap positions.
- R3: With the position strap low, the parity bit for the word sampled on edge k is the value of the parity input sampled on edge k+1.
- R4: With the position strap high, the parity bit for the word sampled on edge k is the value of the parity input sampled on edge k+2.
- R5: On an enabled edge whose result is 1 (odd parity), the error flag is driven to 0.
- R6: Once driven to 0, the error flag stays 0 for HOLD_CYC enabled edges counting the one that set it (default 2). An odd result during the hold restarts the hold. The flag returns to 1 on the first enabled edge after the hold that carries an even result.
- R7: On an edge where both select inputs are 1, the partial-parity output, the error flag and the hold count keep their values. The alignment pipeline still advances on that edge.
- R8: While the reset input is 0, the partial-parity output is 0 and the error flag is 1 at once, whatever the selects and any hold in progress. The block resumes operation two clock edges after reset is released.
- R9: In a chain, the second device receives its half of each word two cycles after the first device does, and its parity input is the first device's partial-parity output. The second device's error flag then reports parity over both halves together with the controller's parity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; release is synchronised inside |
| second_i | input | 1 | Position strap: 0 for a single or first device, 1 for the second device of a chain |
| data_i | input | DATA_W | Checked address and command bits |
| par_i | input | 1 | Late parity input (from the controller, or from the first device's partial-parity output) |
| sel_a_ni | input | 1 | Select A, active low |
| sel_b_ni | input | 1 | Select B, active low; outputs freeze when both selects are 1 |
| ppo_o | output | 1 | Partial-parity result |
| err_no | output | 1 | Error flag, 0 means drive low |

## Verification
The bench builds two copies with DATA_W = 22 and HOLD_CYC = 2. One copy is strapped low and one is strapped high, and the first copy's partial-parity output feeds the second copy's parity input. With this chain, both parity lags and the hand-off between the devices are exercised in the same run. The short hold window means that back-to-back odd words and odd words arriving inside a hold both occur within a few cycles. The same holds for freeze cycles landing in a hold and for a reset issued while the flag is low.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  // Position of a checker inside a two-device chain.
  typedef enum logic {
    CHAIN_FIRST  = 1'b0,
    CHAIN_SECOND = 1'b1
  } chain_pos_e;

  // Largest lag of the parity bit behind its data, in cycles. The data parity
  // is delayed by this many stages, which fixes the result latency.
  localparam int unsigned PAR_LAG_MAX = 2;

  // Result latency from data sample to output update.
  localparam int unsigned RESULT_LAT = PAR_LAG_MAX + 1;

endpackage

// File: rtl/cpc_rst_sync.sv
module cpc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/cpc_align.sv
module cpc_align
  import cpc_pkg::*;
#(
  parameter int unsigned DATA_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  chain_pos_e        pos_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  output logic              sum_o
);

  localparam int unsigned DLY = PAR_LAG_MAX;

  // Data is folded to a single parity bit on capture and only that bit is
  // delayed, stage 0 holding the newest word.
  logic [DLY-1:0] dpar_q;
  logic [DLY-1:0] dpar_d;
  logic           par_q;
  logic           par_d;
  logic           par_sel;
  logic           sum_q;
  logic           sum_d;

  always_comb begin
    dpar_d[0] = ^data_i;
  end

  for (genvar s = 1; s < DLY; s++) begin : g_dly
    always_comb begin
      dpar_d[s] = dpar_q[s-1];
    end
  end

  always_comb begin
    par_d   = par_i;
    // A late parity (second device) is used straight from the pin, an early
    // one (first device) after one register.
    par_sel = (pos_i == CHAIN_SECOND) ? par_i : par_q;
    sum_d   = dpar_q[DLY-1] ^ par_sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dpar_q <= '0;
      par_q  <= 1'b0;
      sum_q  <= 1'b0;
    end else begin
      dpar_q <= dpar_d;
      par_q  <= par_d;
      sum_q  <= sum_d;
    end
  end

  assign sum_o = sum_q;

  // R4
  late_par_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_i == CHAIN_SECOND) |=> (sum_q == ($past(dpar_q[DLY-1]) ^ $past(par_i))));

  // R3
  early_par_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_i == CHAIN_FIRST) |=> (sum_q == ($past(dpar_q[DLY-1]) ^ $past(par_q))));

endmodule

// File: rtl/cpc_out_stage.sv
module cpc_out_stage #(
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic res_i,
  output logic ppo_o,
  output logic err_no
);

  localparam int unsigned CNT_W = $clog2(HOLD_CYC) + 1;
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);

  logic             ppo_q, ppo_d;
  logic             err_nq, err_nd;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ppo_d  = ppo_q;
    err_nd = err_nq;
    cnt_d  = cnt_q;
    if (en_i) begin
      ppo_d = res_i;
      if (res_i) begin
        err_nd = 1'b0;
        cnt_d  = HOLD_LOAD;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        err_nd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ppo_q  <= 1'b0;
      err_nq <= 1'b1;
      cnt_q  <= '0;
    end else begin
      ppo_q  <= ppo_d;
      err_nq <= err_nd;
      cnt_q  <= cnt_d;
    end
  end

  assign ppo_o  = ppo_q;
  assign err_no = err_nq;

  // R5
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && res_i) |=> !err_nq);

  // R6
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_nq |-> (cnt_q == '0));

  if (HOLD_CYC > 1) begin : g_hold_chk
    // R6
    hold_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(err_nq) |=> !err_nq);
  end

  // R7
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(ppo_q) && $stable(err_nq) && $stable(cnt_q)));

endmodule

// File: rtl/casc_parity_chk.sv
module casc_parity_chk
  import cpc_pkg::*;
#(
  parameter int unsigned DATA_W   = 22,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              second_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              sel_a_ni,
  input  logic              sel_b_ni,
  output logic              ppo_o,
  output logic              err_no
);

  logic       rst_sync_n;
  logic       out_en;
  logic       sum;
  chain_pos_e pos;

  always_comb begin
    pos    = chain_pos_e'(second_i);
    out_en = !(sel_a_ni && sel_b_ni);
  end

  cpc_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  cpc_align #(
    .DATA_W (DATA_W)
  ) u_align (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .pos_i  (pos),
    .data_i (data_i),
    .par_i  (par_i),
    .sum_o  (sum)
  );

  cpc_out_stage #(
    .HOLD_CYC (HOLD_CYC)
  ) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (out_en),
    .res_i  (sum),
    .ppo_o  (ppo_o),
    .err_no (err_no)
  );

  // R8
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_force_chk: assert (ppo_o == 1'b0 && err_no == 1'b1);
    end
  end

endmodule

// File: tb/casc_parity_chk_tb.sv
module casc_parity_chk_tb;

  localparam int DW   = 22;
  localparam int HOLD = 2;

  logic          clk;
  logic          rst_n;
  logic [DW-1:0] a_data, b_data;
  logic          par1;
  logic          sel_a_n, sel_b_n;
  logic          ppo1, err1_n, ppo2, err2_n;

  int n_chk  = 0;
  int n_fail = 0;

  casc_parity_chk #(.DATA_W(DW), .HOLD_CYC(HOLD)) u_first (
    .clk_i(clk), .rst_ni(rst_n), .second_i(1'b0), .data_i(a_data), .par_i(par1),
    .sel_a_ni(sel_a_n), .sel_b_ni(sel_b_n), .ppo_o(ppo1), .err_no(err1_n)
  );

  casc_parity_chk #(.DATA_W(DW), .HOLD_CYC(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .second_i(1'b1), .data_i(b_data), .par_i(ppo1),
    .sel_a_ni(sel_a_n), .sel_b_ni(sel_b_n), .ppo_o(ppo2), .err_no(err2_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic p1, e1, p2, e2;
    bit   gated;
  } exp_t;
  exp_t exq[$];

  // reference model state
  logic [3:0] dh1, dh2;
  logic [2:0] ph1, ph2;
  logic       m_ppo1, m_ppo2;
  int         age1, age2;
  // stimulus staging
  logic          p_pend;
  logic [DW-1:0] b_q0, b_q1;

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    dh1 = '0; dh2 = '0; ph1 = '0; ph2 = '0;
    m_ppo1 = 1'b0; m_ppo2 = 1'b0;
    age1 = HOLD; age2 = HOLD;
    p_pend = 1'b0; b_q0 = '0; b_q1 = '0;
  endtask

  // One edge of the reference: result for word k due on edge k+3,
  // first device parity lag 1, second device lag 2.
  task automatic model_step(input logic a_bit, input logic pin1, input logic b_bit, input bit gated);
    logic pin2, raw1, raw2;
    exp_t it;
    pin2 = m_ppo1;
    dh1  = {dh1[2:0], a_bit};
    ph1  = {ph1[1:0], pin1};
    dh2  = {dh2[2:0], b_bit};
    ph2  = {ph2[1:0], pin2};
    raw1 = dh1[3] ^ ph1[2];
    raw2 = dh2[3] ^ ph2[1];
    if (!gated) begin
      m_ppo1 = raw1;
      m_ppo2 = raw2;
      age1 = raw1 ? 0 : ((age1 < HOLD) ? age1 + 1 : age1);
      age2 = raw2 ? 0 : ((age2 < HOLD) ? age2 + 1 : age2);
    end
    it.p1 = m_ppo1; it.e1 = (age1 >= HOLD);
    it.p2 = m_ppo2; it.e2 = (age2 >= HOLD);
    it.gated = gated;
    exq.push_back(it);
  endtask

  // Driver: one word per cycle; controller parity covers both halves.
  task automatic cyc(input logic [DW-1:0] a, input logic [DW-1:0] b,
                     input bit flip, input bit ga, input bit gb);
    logic p_now;
    @(negedge clk);
    p_now   = (^a) ^ (^b) ^ flip;
    a_data  = a;
    par1    = p_pend;
    b_data  = b_q1;
    sel_a_n = ga;
    sel_b_n = gb;
    b_q1    = b_q0;
    b_q0    = b;
    p_pend  = p_now;
    model_step(^a, par1, ^b_data, ga && gb);
  endtask

  task automatic idle_raw(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      a_data = '0; b_data = '0; par1 = 1'b0; sel_a_n = 1'b0; sel_b_n = 1'b0;
    end
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'({$urandom, $urandom});
  endfunction

  // Monitor: pops one expected item per edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exq.size() > 0) begin
        exp_t it;
        string g;
        it = exq.pop_front();
        g = it.gated ? " R7" : "";
        check(ppo1,   it.p1, {"R1 R2 R3 first ppo", g});
        check(err1_n, it.e1, {"R5 R6 first err", g});
        check(ppo2,   it.p2, {"R4 second ppo", g});
        check(err2_n, it.e2, {"R9 R6 second err", g});
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    // R8: immediate effect, even mid-hold
    check(ppo1,   1'b0, "R8 first ppo in reset");
    check(err1_n, 1'b1, "R8 first err in reset");
    check(ppo2,   1'b0, "R8 second ppo in reset");
    check(err2_n, 1'b1, "R8 second err in reset");
    exq.delete();
    model_clear();
    idle_raw(3);
    rst_n = 1'b1;
    idle_raw(5);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    a_data = '0; b_data = '0; par1 = 1'b0; sel_a_n = 1'b0; sel_b_n = 1'b0;
    model_clear();
    #1;
    do_reset();

    // clean traffic: second device must never flag
    for (int i = 0; i < 40; i++) cyc(rnd(), rnd(), 1'b0, 1'b0, 1'b0);
    // single odd word
    cyc(rnd(), rnd(), 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) cyc(rnd(), rnd(), 1'b0, 1'b0, 1'b0);
    // back-to-back odd words
    for (int i = 0; i < 3; i++) cyc(rnd(), rnd(), 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) cyc('0, '0, 1'b0, 1'b0, 1'b0);
    // odd word arriving while the flag is held
    cyc(rnd(), rnd(), 1'b1, 1'b0, 1'b0);
    cyc(rnd(), rnd(), 1'b0, 1'b0, 1'b0);
    cyc(rnd(), rnd(), 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) cyc(rnd(), rnd(), 1'b0, 1'b0, 1'b0);
    // freeze: both selects high, and one-select-high stays enabled
    cyc(rnd(), rnd(), 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) cyc(rnd(), rnd(), 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) cyc(rnd(), rnd(), 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) cyc(rnd(), rnd(), 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) cyc(rnd(), rnd(), 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) cyc(rnd(), rnd(), 1'b0, 1'b0, 1'b0);
    // odd word, then reset while the flag is low
    cyc(rnd(), rnd(), 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) cyc('0, '0, 1'b0, 1'b0, 1'b0);
    do_reset();
    // random mix
    for (int i = 0; i < 250; i++) begin
      bit fl, gt;
      fl = ($urandom_range(0, 9) == 0);
      gt = ($urandom_range(0, 6) == 0);
      cyc(rnd(), rnd(), fl, gt, gt);
    end
    for (int i = 0; i < 8; i++) cyc('0, '0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule